// File: doc/BRIEF.md
# Data Output Edge Conditioner

This block sits between a sampled demodulator bit stream and the data line read by a host microcontroller. It looks at the input only on cycles where a slow tick enable is high. Every output transition therefore lands on a tick, and the time between two output edges is a whole number of ticks. After each output edge the new level is held for a minimum number of ticks. This removes spikes and limits how fast the host sees edges.

The minimum hold depends on the previous edge-to-edge interval of the output. If that interval fell inside a programmable window, the first hold value applies. If it fell outside the window, the second hold value applies. A separate limit bounds how long the output may stay low. When that limit runs out, the output is released high, and it does not follow the input again until the input has been seen high.

The output follows the input only while the receive enable is high. A falling edge of the output during receive serves as the host's wake-up event. All timing values are inputs, so a wrapper or configuration block can set them per baud-rate range.

Top module: `deo_conditioner`

## Requirements
- R1: While `rx_en_i` is low, `data_o` is 1 from the next clock on, and all internal counts (interval, hold and low time) are cleared. After re-enabling, the first output edge is classified using only the ticks seen since the enable.
- R2: `data_o` changes only on the clock edge that samples `tick_i` high while `rx_en_i` is high. With `rx_en_i` high and `tick_i` low, `data_o` keeps its value whatever `dem_i` does.
- R3: When no hold or release lock is in force, a tick that sees `dem_i` different from `data_o` makes `data_o` equal to `dem_i` on that same clock edge.
- R4: After any output edge, `data_o` does not follow the input on the next H-1 ticks, where H is the hold value selected at that edge. An edge-to-edge interval is therefore never shorter than H ticks.
- R5: The interval of an edge is the number of ticks from the previous output edge up to and including the tick of this edge. When lim_lo_i <= interval < lim_hi_i, H is `hold_in_i`.
- R6: When the interval is below `lim_lo_i`, or at or above `lim_hi_i`, H is `hold_out_i`.
- R7: If the input differs from the output while a hold is in force, the output takes the input value on the first tick on which the hold has ended.
- R8: If `data_o` has been low for `low_max_i` ticks (counted from the tick of the falling edge), it is forced to 1 on that tick, even if `dem_i` is still low and a hold is in force. A forced release counts as an output edge.
- R9: After a forced release, `data_o` stays 1 while `dem_i` is low on ticks. A tick that sees `dem_i` high ends this state, and from the next tick on the output follows the input again.
- R10: The interval count saturates at its all-ones value (255 for 8 bits) and does not wrap. A very long interval is therefore classified as outside the window whenever `lim_hi_i` is no larger than that all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable; the input is sampled on cycles where this is high |
| dem_i | input | 1 | Demodulator bit, already synchronous to clk_i |
| rx_en_i | input | 1 | Receive enable; when low, the output is held high and the counts are cleared |
| lim_lo_i | input | CNT_W | Lower bound of the interval window, inclusive |
| lim_hi_i | input | CNT_W | Upper bound of the interval window, exclusive |
| hold_in_i | input | CNT_W | Hold in ticks after an edge whose interval was inside the window |
| hold_out_i | input | CNT_W | Hold in ticks after an edge whose interval was outside the window |
| low_max_i | input | CNT_W | Longest low time of the output in ticks |
| data_o | output | 1 | Conditioned data line |

## Verification
Every result of this block is registered once. An output edge caused by a tick therefore shows on `data_o` right after the clock edge that sampled that tick. The non-tick cycles in between must show no change at all. The driver queues one expected level for each cycle it drives, covering both tick and non-tick cycles. The monitor compares `data_o` against that level a short time after each rising clock edge, so hold lengths, the forced release and the release lock are all checked at the exact tick on which they are due. The bench works out hold expectations by counting ticks from the previous output edge, using the window and hold values given in R4 to R10.

// File: rtl/deo_pkg.sv
package deo_pkg;

    // Follow mode: the output tracks the input subject to the hold.
    // Wait-high mode: entered after a forced release; the input is ignored
    // until it is seen high on a tick.
    typedef enum logic {
        MODE_FOLLOW    = 1'b0,
        MODE_WAIT_HIGH = 1'b1
    } deo_mode_e;

    typedef struct packed {
        logic      data;
        deo_mode_e mode;
    } deo_state_t;

    localparam deo_state_t DEO_IDLE = '{data: 1'b1, mode: MODE_FOLLOW};

endpackage

// File: rtl/deo_sat_counter.sv
module deo_sat_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] step_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // step_o: the value after one more increment, held at the top value
    always_comb begin
        if (cnt_q == CNT_MAX) begin
            step_o = CNT_MAX;
        end else begin
            step_o = cnt_q + CNT_W'(1);
        end
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = step_o;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/deo_window_sel.sv
module deo_window_sel #(
    parameter int unsigned CNT_W = 8
) (
    input  logic [CNT_W-1:0] ivl_i,
    input  logic [CNT_W-1:0] lim_lo_i,
    input  logic [CNT_W-1:0] lim_hi_i,
    input  logic [CNT_W-1:0] hold_in_i,
    input  logic [CNT_W-1:0] hold_out_i,
    output logic [CNT_W-1:0] hold_o
);
    logic in_win;

    always_comb begin
        in_win = (ivl_i >= lim_lo_i) && (ivl_i < lim_hi_i);
        hold_o = in_win ? hold_in_i : hold_out_i;
    end

endmodule

// File: rtl/deo_hold_timer.sv
module deo_hold_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             open_o
);
    logic [CNT_W-1:0] hold_d, hold_q;

    // Loaded with H on an edge; the tick that sees a count of 1 or 0
    // may move the output, i.e. the H-th tick after the edge.
    always_comb begin
        open_o = (hold_q <= CNT_W'(1));
        hold_d = hold_q;
        if (clr_i) begin
            hold_d = '0;
        end else if (load_i) begin
            hold_d = load_val_i;
        end else if (tick_i && (hold_q != '0)) begin
            hold_d = hold_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/deo_conditioner.sv
module deo_conditioner
    import deo_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             dem_i,
    input  logic             rx_en_i,
    input  logic [CNT_W-1:0] lim_lo_i,
    input  logic [CNT_W-1:0] lim_hi_i,
    input  logic [CNT_W-1:0] hold_in_i,
    input  logic [CNT_W-1:0] hold_out_i,
    input  logic [CNT_W-1:0] low_max_i,
    output logic             data_o
);
    deo_state_t       st_d, st_q;
    logic [CNT_W-1:0] ivl_step;
    logic [CNT_W-1:0] low_step;
    logic [CNT_W-1:0] hold_sel;
    logic             hold_open;
    logic             en_tick;
    logic             force_rel;
    logic             follow;
    logic             edge_now;
    logic             ivl_clr;
    logic             low_clr;

    // ticks since the last output edge, saturating
    deo_sat_counter #(.CNT_W(CNT_W)) u_ivl_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (ivl_clr),
        .inc_i  (en_tick),
        .step_o (ivl_step)
    );

    // ticks the output has spent low, saturating
    deo_sat_counter #(.CNT_W(CNT_W)) u_low_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (low_clr),
        .inc_i  (en_tick),
        .step_o (low_step)
    );

    deo_window_sel #(.CNT_W(CNT_W)) u_win (
        .ivl_i      (ivl_step),
        .lim_lo_i   (lim_lo_i),
        .lim_hi_i   (lim_hi_i),
        .hold_in_i  (hold_in_i),
        .hold_out_i (hold_out_i),
        .hold_o     (hold_sel)
    );

    deo_hold_timer #(.CNT_W(CNT_W)) u_hold (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (!rx_en_i),
        .load_i     (edge_now),
        .load_val_i (hold_sel),
        .tick_i     (en_tick),
        .open_o     (hold_open)
    );

    always_comb begin
        en_tick   = rx_en_i && tick_i;
        force_rel = en_tick && !st_q.data && (low_step >= low_max_i);
        follow    = en_tick && (st_q.mode == MODE_FOLLOW) && hold_open
                    && (dem_i != st_q.data);
        edge_now  = force_rel || follow;
        ivl_clr   = !rx_en_i || edge_now;
        low_clr   = !rx_en_i || edge_now || st_q.data;

        st_d = st_q;
        if (!rx_en_i) begin
            st_d = DEO_IDLE;
        end else if (force_rel) begin
            st_d.data = 1'b1;
            st_d.mode = MODE_WAIT_HIGH;
        end else if (follow) begin
            st_d.data = dem_i;
        end else if (en_tick && (st_q.mode == MODE_WAIT_HIGH) && dem_i) begin
            st_d.mode = MODE_FOLLOW;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= DEO_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;

endmodule

// File: rtl/deo_conditioner_chk.sv
module deo_conditioner_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             rx_en_i,
    input logic [CNT_W-1:0] hold_in_i,
    input logic [CNT_W-1:0] hold_out_i,
    input logic [CNT_W-1:0] low_max_i,
    input logic             data_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic             data_prev_q;
    logic [CNT_W-1:0] gap_q;
    logic [CNT_W-1:0] lowt_q;
    logic [CNT_W-1:0] min_hold;

    assign min_hold = (hold_in_i < hold_out_i) ? hold_in_i : hold_out_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_prev_q <= 1'b1;
            gap_q       <= TOP;
            lowt_q      <= '0;
        end else begin
            data_prev_q <= data_o;
            if (!rx_en_i) begin
                gap_q <= TOP;
            end else if (data_o != data_prev_q) begin
                gap_q <= tick_i ? CNT_W'(1) : '0;
            end else if (tick_i && (gap_q != TOP)) begin
                gap_q <= gap_q + CNT_W'(1);
            end
            if (!rx_en_i || data_o) begin
                lowt_q <= '0;
            end else if (tick_i && (lowt_q != TOP)) begin
                lowt_q <= lowt_q + CNT_W'(1);
            end
        end
    end

    // R1: disabled means released high
    a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_en_i |=> data_o);

    // R2: no change between ticks
    a_r2_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_en_i && !tick_i) |=> $stable(data_o));

    // R4: a falling edge never comes sooner than the shorter hold
    a_r4_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_en_i && data_prev_q && !data_o) |-> (gap_q >= min_hold));

    // R8: low time stays below the limit
    a_r8_low_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_en_i && !data_o && (low_max_i != '0)) |-> (lowt_q < low_max_i));

endmodule

bind deo_conditioner deo_conditioner_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .rx_en_i    (rx_en_i),
    .hold_in_i  (hold_in_i),
    .hold_out_i (hold_out_i),
    .low_max_i  (low_max_i),
    .data_o     (data_o)
);

// File: tb/deo_conditioner_tb.sv
module deo_conditioner_tb;
    localparam int unsigned CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_ni = 1'b0;
    logic             tick_i = 1'b0;
    logic             dem_i = 1'b1;
    logic             rx_en_i = 1'b0;
    logic [CNT_W-1:0] lim_lo_i = 8'd4;
    logic [CNT_W-1:0] lim_hi_i = 8'd8;
    logic [CNT_W-1:0] hold_in_i = 8'd3;
    logic [CNT_W-1:0] hold_out_i = 8'd5;
    logic [CNT_W-1:0] low_max_i = 8'd20;
    logic             data_o;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;

    always #10 clk = ~clk;

    deo_conditioner #(.CNT_W(CNT_W)) u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .dem_i      (dem_i),
        .rx_en_i    (rx_en_i),
        .lim_lo_i   (lim_lo_i),
        .lim_hi_i   (lim_hi_i),
        .hold_in_i  (hold_in_i),
        .hold_out_i (hold_out_i),
        .low_max_i  (low_max_i),
        .data_o     (data_o)
    );

    // monitor: one queued level per driven cycle, sampled after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if (data_o !== it.exp) begin
                bad++;
                $display("FAIL %s: data_o=%b expected %b at %0t", it.tag, data_o, it.exp, $time);
            end
        end
    end

    task automatic step(input bit en, input bit d, input bit t, input bit e, input string tag);
        @(negedge clk);
        rx_en_i = en;
        dem_i   = d;
        tick_i  = t;
        q.push_back('{exp: e, tag: tag});
    endtask

    // one tick cycle followed by one idle cycle
    task automatic tk(input bit d, input bit e, input string tag);
        step(1'b1, d, 1'b1, e, tag);
        step(1'b1, d, 1'b0, e, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        // R1: reset state and disabled behaviour
        step(1'b0, 1'b1, 1'b0, 1'b1, "R1");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 1'b1, "R1");
        // R2: enabled, input low, but no tick
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R2");
        tk(1'b1, 1'b1, "R3");
        tk(1'b1, 1'b1, "R3");
        // R3: falls on tick 3 (interval 3, outside -> hold 5)
        tk(1'b0, 1'b0, "R3");
        // R6: held for 4 ticks, R7: pending rise applied on tick 5
        for (int i = 0; i < 4; i++) tk(1'b1, 1'b0, "R6");
        tk(1'b1, 1'b1, "R7");
        // R5: interval 5 inside -> hold 3
        tk(1'b0, 1'b1, "R5");
        tk(1'b0, 1'b1, "R5");
        tk(1'b0, 1'b0, "R5");
        // R4: interval 3 outside -> hold 5; stay low, rise later
        for (int i = 0; i < 6; i++) tk(1'b0, 1'b0, "R4");
        tk(1'b1, 1'b1, "R4");
        for (int i = 0; i < 3; i++) tk(1'b1, 1'b1, "R3");
        tk(1'b0, 1'b0, "R3");
        // R8: forced high on the 20th low tick
        for (int i = 0; i < 19; i++) tk(1'b0, 1'b0, "R8");
        tk(1'b0, 1'b1, "R8");
        // R9: input still low is ignored; a high input re-arms following
        for (int i = 0; i < 8; i++) tk(1'b0, 1'b1, "R9");
        tk(1'b1, 1'b1, "R9");
        tk(1'b0, 1'b0, "R9");
        for (int i = 0; i < 4; i++) tk(1'b0, 1'b0, "R1");
        // R1: disable, then re-enable with cleared interval
        step(1'b0, 1'b0, 1'b1, 1'b1, "R1");
        step(1'b0, 1'b0, 1'b0, 1'b1, "R1");
        for (int i = 0; i < 4; i++) tk(1'b1, 1'b1, "R1");
        tk(1'b0, 1'b0, "R1");
        tk(1'b1, 1'b0, "R1");
        tk(1'b1, 1'b0, "R1");
        tk(1'b1, 1'b1, "R1");
        // R10: 301-tick interval saturates -> outside -> hold 5
        @(negedge clk);
        lim_lo_i = 8'd2;
        lim_hi_i = 8'd255;
        for (int i = 0; i < 300; i++) tk(1'b1, 1'b1, "R10");
        tk(1'b0, 1'b0, "R10");
        for (int i = 0; i < 4; i++) tk(1'b1, 1'b0, "R10");
        tk(1'b1, 1'b1, "R10");
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule